// File: doc/BRIEF.md
# EDID Register Read Engine

This block stands in for an indexed I2C master as seen by display software. The host programs it through four 32-bit registers: pin select, command, status and data. It never drives real I2C pins. A local 128-byte EDID store holds the answers, and a simple write port fills it. A per-port monitor-present input decides whether a selected port can supply EDID bytes at all.

A transfer starts with a pin-select write. A command write then names the target address, an optional start index, the total byte count and a cycle type. The host then reads the data register repeatedly. Each read returns up to four bytes, with the lowest address in the least significant byte.

The transfer phase is held in a three-state machine. The states are IDLE, DATA and WAIT. These events move it:
- PIN_SELECT (a valid port is written) and CTRL_RESET (the clear-interrupt release) both force IDLE.
- START (any odd cycle code) moves to DATA.
- STOP (cycle code 4 after a non-zero stored cycle) moves to IDLE.
- LAST_READ (a data read that drains the remaining count) moves to IDLE for the stop-terminated codes 5 and 7, and to WAIT for the others.

Top module: `edid_reg_engine`

## Requirements
- R1: After reset the status register reads 0x03 (hw-ready bit 0 and NAK bit 1 set, phase IDLE). The pin, command and data registers read 0. `bus_rdata` is 0 in any cycle without a read access.
- R2: Register index 0 is pin select, and only its low 3 bits are kept. A value of 1..PORTS selects port value-1. It clears active (status bit 2), sets hw-ready and wait (status bit 3), forces IDLE, and sets NAK exactly when `mon_present` is low for that port. A value of 0 or above PORTS leaves the status unchanged. Every pin-select write clears the selection, target, availability, pointer and byte count.
- R3: In the command register (index 1), bit 0 is the read direction, bits 7:1 the target, 15:8 the start index, 24:16 the byte count, 27:25 the cycle code, bit 30 software-ready and bit 31 clear-interrupt. Bit 30 is always stored as 0. Target 7'h50 selects the EDID target.
- R4: The EDID pointer is loaded from bits 15:8 only when cycle bit 26 is set in the command write.
- R5: Cycle codes 1, 3, 5 and 7 enter DATA and set active.
- R6: Cycle code 4 forces IDLE, clears active and clears the EDID state only when the previously stored cycle code is non-zero. Otherwise it changes neither phase nor active.
- R7: While stored bit 31 is 1, a command write with bit 31 = 0 clears stored bit 31 only. Status then becomes hw-ready, plus NAK when no EDID is available, and the phase goes IDLE. A write with bit 31 = 1 has no effect at all. While stored bit 31 is 0, writing bit 31 = 1 sets hw-ready.
- R8: When stored bit 0 is 1 and the remaining count (byte count minus pointer) is positive, a data read (index 3) returns and stores min(4, remaining) new bytes, least significant first. Higher bytes keep the previous data word. Otherwise the read returns the stored word and changes nothing.
- R9: A data read with remaining ≤ 4 enters IDLE for codes 5 and 7, and WAIT for the others. It then clears the EDID state.
- R10: A byte is served from the store and advances the pointer only when a valid port with a monitor and target 7'h50 are both selected and the pointer is below 128. Otherwise it is 0x00 and the pointer holds.
- R11: A status read (index 2) returns the old value and then sets in-use (bit 4). A status write with bit 4 = 1 clears in-use, and no other status bit is writable. Bits 6:5 show the phase: 0 IDLE, 1 DATA, 2 WAIT.
- R12: A load-port write replaces one byte of the store, and later reads return the new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_present | input | PORTS | Monitor attached, one bit per port |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| ld_en | input | 1 | Store load strobe |
| ld_addr | input | 7 | Store load address |
| ld_data | input | 8 | Store load byte |

## Verification
The engine is exercised with several read transfers:
- Byte counts that divide into words, which show that packing is correct.
- A count ending on a partial word, which separates the kept upper bytes from the new ones.
- A start index near the end of the store, which shows that reads past byte 127 return zeros without moving the pointer.
- A wrong target and a port with no monitor, which show the gating.
- Each stop-terminated and wait-terminated code, which distinguishes the IDLE and WAIT outcomes.

Stop writes are tried after both zero and non-zero stored cycles, and clear-interrupt writes both while the bit is held and while it is clear. Together these separate the history-dependent cases from the plain field decoding.

// File: rtl/edid_eng_pkg.sv
package edid_eng_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_DATA = 2'd1,
        PH_WAIT = 2'd2
    } phase_e;

    localparam logic [1:0] RIX_PIN  = 2'd0;
    localparam logic [1:0] RIX_CMD  = 2'd1;
    localparam logic [1:0] RIX_STAT = 2'd2;
    localparam logic [1:0] RIX_DATA = 2'd3;

    localparam int CB_RD    = 0;
    localparam int CB_INDEX = 26;
    localparam int CB_SWRDY = 30;
    localparam int CB_CLRIN = 31;

    localparam int SB_HWRDY = 0;
    localparam int SB_NAK   = 1;
    localparam int SB_ACT   = 2;
    localparam int SB_WAIT  = 3;
    localparam int SB_INUSE = 4;

    localparam logic [2:0] CYC_NONE = 3'd0;
    localparam logic [2:0] CYC_STOP = 3'd4;
    localparam logic [6:0] EDID_TGT = 7'h50;

    function automatic logic cyc_starts(input logic [2:0] c);
        return c[0];
    endfunction

    function automatic logic cyc_ends_stop(input logic [2:0] c);
        return c[0] & c[2];
    endfunction

endpackage

// File: rtl/edid_store.sv
module edid_store #(
    parameter int DEPTH = 128,
    parameter int LANES = 4,
    parameter int PW    = 9
) (
    input  logic                      clk,
    input  logic                      ld_en,
    input  logic [$clog2(DEPTH)-1:0]  ld_addr,
    input  logic [7:0]                ld_data,
    input  logic [PW-1:0]             base,
    output logic [LANES-1:0][7:0]     lane_byte,
    output logic [LANES-1:0]          lane_ok
);
    localparam int AW = $clog2(DEPTH);
    localparam int XW = PW + 1;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (ld_en) mem[ld_addr] <= ld_data;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [XW-1:0] a;
        assign a            = {1'b0, base} + XW'(i);
        assign lane_ok[i]   = a < XW'(DEPTH);
        assign lane_byte[i] = lane_ok[i] ? mem[a[AW-1:0]] : 8'h00;
    end

endmodule

// File: rtl/edid_byte_packer.sv
module edid_byte_packer #(
    parameter int LANES = 4
) (
    input  logic [LANES-1:0][7:0]  lane_byte,
    input  logic [LANES-1:0]       lane_ok,
    input  logic                   gate,
    input  logic [2:0]             nbytes,
    input  logic [LANES*8-1:0]     old_word,
    output logic [LANES*8-1:0]     new_word,
    output logic [2:0]             adv
);
    logic [LANES-1:0] take;
    logic [LANES-1:0] served;

    for (genvar i = 0; i < LANES; i++) begin : g_pack
        assign take[i]   = 3'(i) < nbytes;
        assign served[i] = take[i] & gate & lane_ok[i];
        assign new_word[i*8 +: 8] = take[i] ? (served[i] ? lane_byte[i] : 8'h00)
                                            : old_word[i*8 +: 8];
    end

    always_comb begin
        adv = 3'd0;
        for (int k = 0; k < LANES; k++) adv = adv + {2'b00, served[k]};
    end

endmodule

// File: rtl/edid_phase_ctl.sv
module edid_phase_ctl
    import edid_eng_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   ev_go_idle,
    input  logic   ev_start,
    input  logic   ev_last,
    input  logic   last_stop,
    output phase_e phase
);
    phase_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE: begin
                if (ev_start)     state_d = PH_DATA;
                else if (ev_last) state_d = last_stop ? PH_IDLE : PH_WAIT;
            end
            PH_DATA: begin
                if (ev_go_idle)   state_d = PH_IDLE;
                else if (ev_last) state_d = last_stop ? PH_IDLE : PH_WAIT;
            end
            PH_WAIT: begin
                if (ev_go_idle)   state_d = PH_IDLE;
                else if (ev_start) state_d = PH_DATA;
                else if (ev_last) state_d = last_stop ? PH_IDLE : PH_WAIT;
            end
            default: state_d = PH_IDLE;
        endcase
    end

    assign phase = state_q;

    p_start_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_start |=> state_q == PH_DATA);

    p_last_leaves_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_last && !ev_start) |=> state_q != PH_DATA);

    p_idle_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_go_idle |=> state_q == PH_IDLE);

endmodule

// File: rtl/edid_reg_engine.sv
module edid_reg_engine
    import edid_eng_pkg::*;
#(
    parameter int PORTS = 4,
    parameter int DEPTH = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PORTS-1:0] mon_present,
    input  logic             bus_valid,
    input  logic             bus_write,
    input  logic [1:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic             ld_en,
    input  logic [6:0]       ld_addr,
    input  logic [7:0]       ld_data
);
    localparam int DW    = 32;
    localparam int LANES = DW / 8;
    localparam int CW    = 9;
    localparam int PW    = CW;

    logic [2:0]  pin_q;
    logic [31:0] cmd_q, data_q;
    logic        hw_q, nak_q, act_q, wait_q, use_q;
    logic        sel_q, tgt_q, avail_q;
    logic [PW-1:0] ptr_q;
    logic [CW-1:0] tot_q;
    phase_e      phase;

    logic acc_rd, acc_wr;
    logic pin_wr, pin_ok, mon_hit;
    logic [7:0] mon_pad;
    logic cmd_wr, ctl_reset, cmd_live;
    logic [31:0] w_cmd;
    logic [2:0] new_cyc, prev_cyc;
    logic ev_start, ev_stop, ev_last, data_rd, has_left, gate;
    logic signed [CW:0] left;
    logic [2:0] nbytes, adv;
    logic [LANES-1:0][7:0] lane_byte;
    logic [LANES-1:0] lane_ok;
    logic [DW-1:0] packed_word;
    logic [31:0] stat_word;

    always_comb begin
        acc_rd    = bus_valid & ~bus_write;
        acc_wr    = bus_valid & bus_write;
        mon_pad   = {{(8-PORTS){1'b0}}, mon_present};
        pin_wr    = acc_wr && bus_addr == RIX_PIN;
        pin_ok    = bus_wdata[2:0] != 3'd0 && {29'd0, bus_wdata[2:0]} <= PORTS;
        mon_hit   = mon_pad[bus_wdata[2:0] - 3'd1];
        cmd_wr    = acc_wr && bus_addr == RIX_CMD;
        ctl_reset = cmd_wr && cmd_q[CB_CLRIN] && !bus_wdata[CB_CLRIN];
        cmd_live  = cmd_wr && !cmd_q[CB_CLRIN];
        w_cmd     = bus_wdata & ~(32'd1 << CB_SWRDY);
        new_cyc   = w_cmd[27:25];
        prev_cyc  = cmd_q[27:25];
        ev_start  = cmd_live && cyc_starts(new_cyc);
        ev_stop   = cmd_live && new_cyc == CYC_STOP && prev_cyc != CYC_NONE;
        left      = signed'({1'b0, tot_q}) - signed'({1'b0, ptr_q});
        has_left  = left > 0;
        data_rd   = acc_rd && bus_addr == RIX_DATA && cmd_q[CB_RD];
        ev_last   = data_rd && has_left && left <= 4;
        nbytes    = (has_left && left <= 4) ? left[2:0] : 3'd4;
        gate      = sel_q & tgt_q & avail_q;
        stat_word = {25'd0, phase, use_q, wait_q, act_q, nak_q, hw_q};
    end

    edid_store #(.DEPTH(DEPTH), .LANES(LANES), .PW(PW)) u_store (
        .clk(clk), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .base(ptr_q), .lane_byte(lane_byte), .lane_ok(lane_ok)
    );

    edid_byte_packer #(.LANES(LANES)) u_pack (
        .lane_byte(lane_byte), .lane_ok(lane_ok), .gate(gate),
        .nbytes(nbytes), .old_word(data_q), .new_word(packed_word), .adv(adv)
    );

    edid_phase_ctl u_phase (
        .clk(clk), .rst_n(rst_n),
        .ev_go_idle((pin_wr && pin_ok) || ctl_reset || ev_stop),
        .ev_start(ev_start), .ev_last(ev_last),
        .last_stop(cyc_ends_stop(cmd_q[27:25])),
        .phase(phase)
    );

    // EDID selection state: pointer, count, target, availability
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= 1'b0; tgt_q <= 1'b0; avail_q <= 1'b0;
            ptr_q <= '0;   tot_q <= '0;
        end else if (pin_wr) begin
            sel_q <= pin_ok; tgt_q <= 1'b0; avail_q <= pin_ok & mon_hit;
            ptr_q <= '0;     tot_q <= '0;
        end else if (ev_stop) begin
            sel_q <= 1'b0; tgt_q <= 1'b0; avail_q <= 1'b0;
            ptr_q <= '0;   tot_q <= '0;
        end else if (cmd_live) begin
            tot_q <= w_cmd[24:16];
            if (w_cmd[7:1] == EDID_TGT) tgt_q <= 1'b1;
            if (w_cmd[CB_INDEX])        ptr_q <= {1'b0, w_cmd[15:8]};
        end else if (ev_last) begin
            sel_q <= 1'b0; tgt_q <= 1'b0; avail_q <= 1'b0;
            ptr_q <= '0;   tot_q <= '0;
        end else if (data_rd && has_left) begin
            ptr_q <= ptr_q + PW'(adv);
        end
    end

    // Visible registers and status flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q <= '0; cmd_q <= '0; data_q <= '0;
            hw_q <= 1'b1; nak_q <= 1'b1; act_q <= 1'b0; wait_q <= 1'b0; use_q <= 1'b0;
        end else begin
            if (pin_wr) begin
                pin_q <= bus_wdata[2:0];
                if (pin_ok) begin
                    act_q <= 1'b0; hw_q <= 1'b1; wait_q <= 1'b1; nak_q <= ~mon_hit;
                end
            end
            if (ctl_reset) begin
                cmd_q[CB_CLRIN] <= 1'b0;
                hw_q <= 1'b1; nak_q <= ~avail_q; act_q <= 1'b0;
                wait_q <= 1'b0; use_q <= 1'b0;
            end
            if (cmd_live) begin
                cmd_q <= w_cmd;
                if (w_cmd[CB_CLRIN]) hw_q <= 1'b1;
                if (ev_start)        act_q <= 1'b1;
                if (ev_stop)         act_q <= 1'b0;
            end
            if (acc_rd && bus_addr == RIX_STAT) use_q <= 1'b1;
            if (acc_wr && bus_addr == RIX_STAT && bus_wdata[SB_INUSE]) use_q <= 1'b0;
            if (data_rd && has_left) data_q <= packed_word;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (acc_rd) begin
            unique case (bus_addr)
                RIX_PIN:  bus_rdata = {29'd0, pin_q};
                RIX_CMD:  bus_rdata = cmd_q;
                RIX_STAT: bus_rdata = stat_word;
                RIX_DATA: bus_rdata = (data_rd && has_left) ? packed_word : data_q;
                default:  bus_rdata = '0;
            endcase
        end
    end

    p_active_in_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_DATA |-> act_q);

    p_swrdy_dropped_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_live |=> !cmd_q[CB_SWRDY]);

    p_inuse_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && bus_addr == RIX_STAT) |=> use_q);

    p_pin_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_wr && pin_ok) |=> (phase == PH_IDLE && !act_q && wait_q && hw_q));

    p_ptr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && has_left && !ev_last) |=> ptr_q <= $past(ptr_q) + 9'd4);

    p_clr_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_q[CB_CLRIN] && bus_wdata[CB_CLRIN]) |=> $stable(cmd_q));

endmodule

// File: tb/edid_reg_engine_test.sv
`timescale 1ns/1ps
module edid_reg_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  mon_present = 4'b0101;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        ld_en = 1'b0;
    logic [6:0]  ld_addr = 7'd0;
    logic [7:0]  ld_data = 8'd0;

    int checks = 0, failures = 0;
    bit running = 0;

    always #2 clk = ~clk;

    edid_reg_engine uut (
        .clk(clk), .rst_n(rst_n), .mon_present(mon_present),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data)
    );

    // behavioural reference state
    int m_pin, m_hw, m_nak, m_act, m_wait, m_use, m_ph;
    int m_sel, m_tgt, m_av, m_ptr, m_tot;
    bit [31:0] m_cmd, m_data;
    int mem [128];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic void m_clear();
        m_sel = 0; m_tgt = 0; m_av = 0; m_ptr = 0; m_tot = 0;
    endfunction

    function automatic bit [31:0] m_fetch(output int new_ptr, output bit did);
        bit [31:0] w = m_data;
        int left = m_tot - m_ptr;
        int p = m_ptr;
        did = 0;
        new_ptr = m_ptr;
        if (m_cmd[0] && left > 0) begin
            did = 1;
            for (int i = 0; i < ((left < 4) ? left : 4); i++) begin
                int b = 0;
                if (m_sel && m_tgt && m_av && p < 128) begin b = mem[p]; p++; end
                w[i*8 +: 8] = b[7:0];
            end
            new_ptr = p;
        end
        return w;
    endfunction

    function automatic bit [31:0] m_read(input int a);
        int np; bit d;
        case (a)
            0: return 32'(m_pin);
            1: return m_cmd;
            2: return 32'(m_hw | (m_nak << 1) | (m_act << 2) | (m_wait << 3) | (m_use << 4) | (m_ph << 5));
            default: return m_fetch(np, d);
        endcase
    endfunction

    function automatic void m_apply(input bit wr, input int a, input bit [31:0] d);
        if (!wr) begin
            if (a == 2) m_use = 1;
            if (a == 3) begin
                int np; bit did; int left = m_tot - m_ptr;
                bit [31:0] w = m_fetch(np, did);
                if (did) begin
                    m_data = w; m_ptr = np;
                    if (left <= 4) begin
                        m_ph = (m_cmd[27:25] == 5 || m_cmd[27:25] == 7) ? 0 : 2;
                        m_clear();
                    end
                end
            end
        end else if (a == 0) begin
            int v = int'(d[2:0]);
            m_pin = v; m_clear();
            if (v != 0 && v <= 4) begin
                m_sel = 1; m_ph = 0; m_act = 0; m_hw = 1; m_wait = 1;
                if (mon_present[v-1]) begin m_av = 1; m_nak = 0; end
                else m_nak = 1;
            end
        end else if (a == 1) begin
            if (m_cmd[31]) begin
                if (!d[31]) begin
                    m_cmd[31] = 0; m_hw = 1; m_nak = m_av ? 0 : 1;
                    m_act = 0; m_wait = 0; m_use = 0; m_ph = 0;
                end
            end else begin
                bit [31:0] w = d; int c;
                w[30] = 0;
                if (w[31]) m_hw = 1;
                m_tot = int'(w[24:16]);
                if (w[7:1] == 7'h50) m_tgt = 1;
                if (w[26]) m_ptr = int'(w[15:8]);
                c = int'(w[27:25]);
                if (c == 4) begin
                    if (m_cmd[27:25] != 0) begin m_clear(); m_ph = 0; m_act = 0; end
                end else if (c % 2 == 1) begin
                    m_ph = 1; m_act = 1;
                end
                m_cmd = w;
            end
        end else if (a == 2) begin
            if (d[4]) m_use = 0;
        end
    endfunction

    task automatic access(input bit wr, input int a, input bit [31:0] d, input string req);
        bit [31:0] exp;
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_addr = 2'(a); bus_wdata = d;
        exp = wr ? 32'd0 : m_read(a);
        #1;
        check(bus_rdata == exp, req, bus_rdata, exp);
        @(posedge clk);
        m_apply(wr, a, d);
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic load(input int a, input int v);
        @(negedge clk);
        ld_en = 1'b1; ld_addr = 7'(a); ld_data = 8'(v);
        @(posedge clk);
        mem[a] = v;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    function automatic bit [31:0] cmd(input int tgt, input int idx, input int cnt, input int cyc, input bit rd);
        return (32'(cyc) << 25) | (32'(cnt) << 16) | (32'(idx) << 8) | (32'(tgt) << 1) | 32'(rd);
    endfunction

    // every clock without an access: read data must be zero
    always @(negedge clk) begin
        #1;
        if (running && !bus_valid) check(bus_rdata == 32'd0, "R1 idle", bus_rdata, 0);
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        m_pin = 0; m_hw = 1; m_nak = 1; m_act = 0; m_wait = 0; m_use = 0; m_ph = 0;
        m_cmd = 0; m_data = 0; m_clear();
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 128; i++) load(i, (i * 7 + 3) & 255);
        running = 1;

        // R1 reset values (status read sets in-use afterwards, R11)
        access(0, 0, 0, "R1 pin");
        access(0, 1, 0, "R1 cmd");
        access(0, 3, 0, "R1 data");
        access(0, 2, 0, "R1 status");
        access(0, 2, 0, "R11 inuse set");
        access(1, 2, 32'hFF, "R11 write");
        access(0, 2, 0, "R11 only inuse cleared");

        // R2 pin select
        access(1, 0, 1, "R2 present");
        access(0, 2, 0, "R2 status present");
        access(1, 0, 2, "R2 absent");
        access(0, 2, 0, "R2 status absent");
        access(1, 0, 0, "R2 zero");
        access(0, 2, 0, "R2 zero no status change");
        access(1, 0, 6, "R2 out of range");
        access(0, 0, 0, "R2 pin low bits");

        // R3 R5 R8 R9 stop-terminated read of 10 bytes
        access(1, 0, 1, "R2");
        access(1, 1, cmd(7'h50, 0, 10, 7, 1) | 32'h4000_0000, "R3 write");
        access(0, 1, 0, "R3 swrdy dropped");
        access(0, 2, 0, "R5 data phase");
        access(0, 3, 0, "R8 word0");
        access(0, 3, 0, "R8 word1");
        access(0, 3, 0, "R8 partial keeps upper");
        access(0, 2, 0, "R9 idle after stop code");
        access(0, 3, 0, "R9 no more bytes");

        // R4 index bit
        access(1, 0, 1, "R4");
        access(1, 1, cmd(7'h50, 20, 8, 1, 1), "R4 no index");
        access(0, 3, 0, "R4 from zero");
        access(1, 0, 1, "R4");
        access(1, 1, cmd(7'h50, 20, 28, 3, 1), "R4 index");
        access(0, 3, 0, "R4 from 20");

        // R10 past end, R9 wait ending
        access(1, 0, 1, "R10");
        access(1, 1, cmd(7'h50, 126, 132, 3, 1), "R10 cmd");
        access(0, 3, 0, "R10 wrap zero");
        access(0, 3, 0, "R10 all zero");
        access(0, 2, 0, "R9 wait phase");

        // R10 wrong target and absent monitor
        access(1, 0, 1, "R10");
        access(1, 1, cmd(7'h51, 0, 4, 1, 1), "R10 bad target");
        access(0, 3, 0, "R10 bad target zeros");
        access(1, 0, 2, "R10");
        access(1, 1, cmd(7'h50, 0, 4, 5, 1), "R10 no monitor");
        access(0, 3, 0, "R10 no monitor zeros");
        access(0, 2, 0, "R9 idle code5");

        // R8 read direction clear
        access(1, 0, 1, "R8");
        access(1, 1, cmd(7'h50, 0, 8, 1, 0), "R8 write dir");
        access(0, 3, 0, "R8 unchanged");

        // R6 stop handling
        access(1, 1, cmd(7'h50, 0, 8, 1, 1), "R6 start");
        access(1, 1, cmd(7'h50, 0, 8, 4, 1), "R6 stop");
        access(0, 2, 0, "R6 idle after stop");
        access(1, 1, cmd(7'h50, 0, 8, 1, 1), "R6 start");
        access(1, 1, cmd(7'h50, 0, 8, 0, 1), "R6 none");
        access(1, 1, cmd(7'h50, 0, 8, 4, 1), "R6 stop after none");
        access(0, 2, 0, "R6 still data");

        // R7 clear-interrupt
        access(1, 0, 1, "R7");
        access(1, 1, 32'h8000_0000 | cmd(7'h50, 0, 8, 1, 1), "R7 set");
        access(0, 1, 0, "R7 stored");
        access(1, 1, 32'h8000_0000, "R7 held ignored");
        access(0, 1, 0, "R7 unchanged");
        access(1, 1, 32'h0, "R7 release");
        access(0, 1, 0, "R7 bit cleared");
        access(0, 2, 0, "R7 status reset");
        access(1, 0, 2, "R7");
        access(1, 1, 32'h8000_0000, "R7 set absent");
        access(1, 1, 32'h0, "R7 release absent");
        access(0, 2, 0, "R7 nak when no edid");

        // R12 store reload
        load(0, 8'hA5);
        access(1, 0, 1, "R12");
        access(1, 1, cmd(7'h50, 0, 2, 7, 1), "R12 cmd");
        access(0, 3, 0, "R12 new byte");

        running = 0;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule